// File: doc/BRIEF.md
# PCI Target Configuration Register Bank

This block holds the Type 0 configuration header of a simple PCI target. In the cycle that opens a transaction (FRAME# low while the bank is idle), it captures the dword index from AD[7:2] and classifies the bus command on C/BE#[3:0]. In the data phase that follows, a configuration read drives the addressed header dword on a read-data output. A configuration write updates the addressed register. Either one completes on the first rising clock edge at which IRDY# and TRDY# are both low. Exactly one data phase follows each address phase, and the bus returns to idle before the next address phase.

Three header locations can be written: the Command half of dword 04h, one 4 KB memory base address at 10h, and the Interrupt Line byte of 3Ch. All identification fields are fixed by module parameters. Every other offset reads as zero and discards writes. The writable values are also brought out as outputs, so that the rest of the target can use the command bits, the decode base and the interrupt line.

Top module: `pci_cfg_regbank`

## Requirements
- R1: A synchronous active-low reset sets Command, the base address register and Interrupt Line to zero. While no configuration read is in its data phase, rd_data_o is 00000000h.
- R2: A configuration read returns these fixed parameter values:
  - dword 00h (index 0) is {DEVICE_ID, VENDOR_ID}.
  - 08h (index 2) is {CLASS_CODE, REVISION_ID}.
  - 0Ch (index 3) is {8'h00, HEADER_TYPE, 8'h00, 8'h00}.
  - 2Ch (index 11) is {SUBSYS_ID, SUBSYS_VENDOR_ID}.
- R3: Dword 04h (index 1) reads as {STATUS_VALUE, Command}. A write to it changes only the 16-bit Command field, and the write is visible on cmd_o.
- R4: The base address register at 10h (index 4) decodes a window of 2^BAR_ADDR_LSB bytes (4 KB by default). Its bits below BAR_ADDR_LSB always read as zero, so writing FFFFFFFFh reads back FFFFF000h.
- R5: Dword 3Ch (index 15) reads as {MAX_LATENCY, MIN_GRANT, INT_PIN, Interrupt Line}. Only the low byte, Interrupt Line, can be written.
- R6: Byte enables are taken from C/BE#[3:0] during the data phase and are active low: bit n equal to 0 enables AD[8n+7:8n]. Disabled bytes of the addressed register keep their old value.
- R7: A write is committed only at a rising edge where IRDY# and TRDY# are both low. Data-phase cycles where either one is high change no register.
- R8: The command code 1011 (C/BE#[3:0] during the address phase) marks a configuration write, and 1010 marks a configuration read. Any other code changes no register, and for such a code rd_data_o stays 00000000h.
- R9: Writes to every dword other than 04h, 10h and 3Ch are ignored, including the reserved 34h/38h and 40h through FCh. Those offsets, and any dword not listed above, read as 00000000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n_i | input | 1 | Transaction start marker, active low |
| ad_i | input | 32 | Address in the address phase, write data in the data phase |
| cbe_n_i | input | 4 | Bus command in the address phase, active-low byte enables in the data phase |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| rd_data_o | output | 32 | Header dword returned during a configuration read data phase |
| cmd_o | output | 16 | Current Command register |
| bar_o | output | 32 | Current memory base address register |
| int_line_o | output | 8 | Current Interrupt Line register |

## Verification
The bench holds data phases with every ready combination except both-low, and checks after each such cycle that no register moved. A bank that committed on a single ready would change state early. Partial byte enables test lane gating: an inverted enable sense writes the wrong bytes. All-ones sizing writes test the BAR low-bit masking, and writes with the memory-write command to writable offsets must leave every register untouched. Writes and reads to reserved dwords, to 40h–FCh, and with stray upper address bits show whether the offset decode is too loose.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    localparam int DW_IDX_W = 6;
    localparam int NUM_WR   = 3;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam logic [DW_IDX_W-1:0] DW_ID    = 6'h00;
    localparam logic [DW_IDX_W-1:0] DW_CMDST = 6'h01;
    localparam logic [DW_IDX_W-1:0] DW_CLASS = 6'h02;
    localparam logic [DW_IDX_W-1:0] DW_MISC  = 6'h03;
    localparam logic [DW_IDX_W-1:0] DW_BAR   = 6'h04;
    localparam logic [DW_IDX_W-1:0] DW_SUBS  = 6'h0B;
    localparam logic [DW_IDX_W-1:0] DW_INTR  = 6'h0F;

    // writable dwords; strobe bit k targets WR_DW[k]
    localparam int WR_CMD  = 0;
    localparam int WR_BAR  = 1;
    localparam int WR_INTL = 2;
    localparam logic [DW_IDX_W-1:0] WR_DW [NUM_WR] = '{DW_CMDST, DW_BAR, DW_INTR};

    typedef enum logic [1:0] {
        TK_NONE   = 2'd0,
        TK_CFG_RD = 2'd1,
        TK_CFG_WR = 2'd2,
        TK_OTHER  = 2'd3
    } txn_kind_e;

    typedef struct packed {
        logic                active;
        txn_kind_e           kind;
        logic [DW_IDX_W-1:0] dw;
    } phase_s;

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] bar;
        logic [31:0] intl;
    } regs_s;

endpackage

// File: rtl/pci_cfg_phase.sv
module pci_cfg_phase
    import pci_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n_i,
    input  logic [DW_IDX_W-1:0] addr_dw_i,
    input  logic [3:0]          cbe_n_i,
    input  logic                irdy_n_i,
    input  logic                trdy_n_i,
    output logic                active_o,
    output txn_kind_e           kind_o,
    output logic [DW_IDX_W-1:0] dw_o,
    output logic                done_o
);

    phase_s ph_d, ph_q;

    function automatic txn_kind_e classify(input logic [3:0] code);
        if (code == CMD_CFG_RD)      return TK_CFG_RD;
        else if (code == CMD_CFG_WR) return TK_CFG_WR;
        else                         return TK_OTHER;
    endfunction

    always_comb begin
        ph_d = ph_q;
        if (ph_q.active) begin
            if (!irdy_n_i && !trdy_n_i) begin
                ph_d.active = 1'b0;
                ph_d.kind   = TK_NONE;
            end
        end else if (!frame_n_i) begin
            ph_d.active = 1'b1;
            ph_d.kind   = classify(cbe_n_i);
            ph_d.dw     = addr_dw_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '{active: 1'b0, kind: TK_NONE, dw: '0};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign active_o = ph_q.active;
    assign kind_o   = ph_q.kind;
    assign dw_o     = ph_q.dw;
    assign done_o   = ph_q.active && !irdy_n_i && !trdy_n_i;

    // R8
    active_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.active |-> (ph_q.kind != TK_NONE));

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !ph_q.active);

endmodule

// File: rtl/pci_cfg_wr_decode.sv
module pci_cfg_wr_decode
    import pci_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_i,
    input  txn_kind_e           kind_i,
    input  logic [DW_IDX_W-1:0] dw_i,
    output logic [NUM_WR-1:0]   strb_o
);

    logic wr_cycle;
    assign wr_cycle = done_i && (kind_i == TK_CFG_WR);

    for (genvar g = 0; g < NUM_WR; g++) begin : g_strb
        assign strb_o[g] = wr_cycle && (dw_i == WR_DW[g]);
    end

    // R9
    strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb_o));

    // R8
    strb_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != TK_CFG_WR) |-> (strb_o == '0));

endmodule

// File: rtl/pci_cfg_store.sv
module pci_cfg_store
    import pci_cfg_pkg::*;
#(
    parameter int BAR_ADDR_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WR-1:0] strb_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        be_n_i,
    output regs_s             regs_o
);

    localparam logic [31:0] CMD_MASK  = 32'h0000_FFFF;
    localparam logic [31:0] BAR_MASK  = ~((32'd1 << BAR_ADDR_LSB) - 32'd1);
    localparam logic [31:0] INTL_MASK = 32'h0000_00FF;

    regs_s regs_d, regs_q;

    function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                               input logic [31:0] nxt,
                                               input logic [3:0]  ben,
                                               input logic [31:0] mask);
        logic [31:0] res;
        res = cur;
        for (int b = 0; b < 4; b++) begin
            if (!ben[b]) res[b*8 +: 8] = nxt[b*8 +: 8];
        end
        return res & mask;
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (strb_i[WR_CMD])
            regs_d.cmd  = lane_merge(regs_q.cmd, wdata_i, be_n_i, CMD_MASK);
        if (strb_i[WR_BAR])
            regs_d.bar  = lane_merge(regs_q.bar, wdata_i, be_n_i, BAR_MASK);
        if (strb_i[WR_INTL])
            regs_d.intl = lane_merge(regs_q.intl, wdata_i, be_n_i, INTL_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i[WR_CMD] |=> $stable(regs_q.cmd));

    // R7
    bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i[WR_BAR] |=> $stable(regs_q.bar));

    // R6
    cmd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_i[WR_CMD] && be_n_i[1]) |=> (regs_q.cmd[15:8] == $past(regs_q.cmd[15:8])));

    // R5
    intl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.intl[31:8] == 24'h0);

endmodule

// File: rtl/pci_cfg_rd_mux.sv
module pci_cfg_rd_mux
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID        = 16'h0000,
    parameter logic [15:0] DEVICE_ID        = 16'h0000,
    parameter logic [15:0] STATUS_VALUE     = 16'h0000,
    parameter logic [23:0] CLASS_CODE       = 24'h000000,
    parameter logic [7:0]  REVISION_ID      = 8'h00,
    parameter logic [7:0]  HEADER_TYPE      = 8'h00,
    parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h0000,
    parameter logic [15:0] SUBSYS_ID        = 16'h0000,
    parameter logic [7:0]  INT_PIN          = 8'h00,
    parameter logic [7:0]  MIN_GRANT        = 8'h00,
    parameter logic [7:0]  MAX_LATENCY      = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en_i,
    input  logic [DW_IDX_W-1:0] dw_i,
    input  regs_s               regs_i,
    output logic [31:0]         rd_data_o
);

    logic [31:0] sel_d;

    always_comb begin
        unique case (dw_i)
            DW_ID:    sel_d = {DEVICE_ID, VENDOR_ID};
            DW_CMDST: sel_d = {STATUS_VALUE, 16'h0000} | regs_i.cmd;
            DW_CLASS: sel_d = {CLASS_CODE, REVISION_ID};
            DW_MISC:  sel_d = {8'h00, HEADER_TYPE, 16'h0000};
            DW_BAR:   sel_d = regs_i.bar;
            DW_SUBS:  sel_d = {SUBSYS_ID, SUBSYS_VENDOR_ID};
            DW_INTR:  sel_d = {MAX_LATENCY, MIN_GRANT, INT_PIN, 8'h00} | regs_i.intl;
            default:  sel_d = 32'h0000_0000;
        endcase
    end

    assign rd_data_o = rd_en_i ? sel_d : 32'h0000_0000;

    // R9
    rd_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (dw_i >= 6'h10)) |-> (rd_data_o == 32'h0));

endmodule

// File: rtl/pci_cfg_regbank.sv
module pci_cfg_regbank
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID        = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID        = 16'h3C4D,
    parameter logic [15:0] STATUS_VALUE     = 16'h0000,
    parameter logic [23:0] CLASS_CODE       = 24'h058000,
    parameter logic [7:0]  REVISION_ID      = 8'h01,
    parameter logic [7:0]  HEADER_TYPE      = 8'h00,
    parameter logic [15:0] SUBSYS_VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] SUBSYS_ID        = 16'h0001,
    parameter logic [7:0]  INT_PIN          = 8'h01,
    parameter logic [7:0]  MIN_GRANT        = 8'h00,
    parameter logic [7:0]  MAX_LATENCY      = 8'h00,
    parameter int          BAR_ADDR_LSB     = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n_i,
    input  logic [31:0] ad_i,
    input  logic [3:0]  cbe_n_i,
    input  logic        irdy_n_i,
    input  logic        trdy_n_i,
    output logic [31:0] rd_data_o,
    output logic [15:0] cmd_o,
    output logic [31:0] bar_o,
    output logic [7:0]  int_line_o
);

    logic                active;
    txn_kind_e           kind;
    logic [DW_IDX_W-1:0] dw;
    logic                done;
    logic [NUM_WR-1:0]   strb;
    regs_s               regs;
    logic                rd_en;

    pci_cfg_phase i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n_i (frame_n_i),
        .addr_dw_i (ad_i[7:2]),
        .cbe_n_i   (cbe_n_i),
        .irdy_n_i  (irdy_n_i),
        .trdy_n_i  (trdy_n_i),
        .active_o  (active),
        .kind_o    (kind),
        .dw_o      (dw),
        .done_o    (done)
    );

    pci_cfg_wr_decode i_wr_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done),
        .kind_i (kind),
        .dw_i   (dw),
        .strb_o (strb)
    );

    pci_cfg_store #(
        .BAR_ADDR_LSB (BAR_ADDR_LSB)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb_i  (strb),
        .wdata_i (ad_i),
        .be_n_i  (cbe_n_i),
        .regs_o  (regs)
    );

    assign rd_en = active && (kind == TK_CFG_RD);

    pci_cfg_rd_mux #(
        .VENDOR_ID        (VENDOR_ID),
        .DEVICE_ID        (DEVICE_ID),
        .STATUS_VALUE     (STATUS_VALUE),
        .CLASS_CODE       (CLASS_CODE),
        .REVISION_ID      (REVISION_ID),
        .HEADER_TYPE      (HEADER_TYPE),
        .SUBSYS_VENDOR_ID (SUBSYS_VENDOR_ID),
        .SUBSYS_ID        (SUBSYS_ID),
        .INT_PIN          (INT_PIN),
        .MIN_GRANT        (MIN_GRANT),
        .MAX_LATENCY      (MAX_LATENCY)
    ) i_rd_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .dw_i      (dw),
        .regs_i    (regs),
        .rd_data_o (rd_data_o)
    );

    assign cmd_o      = regs.cmd[15:0];
    assign bar_o      = regs.bar;
    assign int_line_o = regs.intl[7:0];

    // R4
    bar_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bar_o[BAR_ADDR_LSB-1:0] == '0);

    // R7
    strb_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb != '0) |-> (!irdy_n_i && !trdy_n_i));

    // R1
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (rd_data_o == 32'h0));

endmodule

// File: tb/test_pci_cfg_regbank.sv
module test_pci_cfg_regbank;

    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] P_VID  = 16'hBEEF;
    localparam logic [15:0] P_DID  = 16'h5A17;
    localparam logic [15:0] P_STAT = 16'h0010;
    localparam logic [23:0] P_CLS  = 24'h0C0330;
    localparam logic [7:0]  P_REV  = 8'h4E;
    localparam logic [7:0]  P_HDR  = 8'h00;
    localparam logic [15:0] P_SVID = 16'h7711;
    localparam logic [15:0] P_SID  = 16'h2299;
    localparam logic [7:0]  P_PIN  = 8'h02;
    localparam logic [7:0]  P_MGNT = 8'h05;
    localparam logic [7:0]  P_MLAT = 8'h0A;

    localparam logic [3:0] C_RD  = 4'b1010;
    localparam logic [3:0] C_WR  = 4'b1011;
    localparam logic [3:0] C_MWR = 4'b0111;
    localparam logic [3:0] C_MRD = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic [31:0] rd_data;
    logic [15:0] cmd_out;
    logic [31:0] bar_out;
    logic [7:0]  intl_out;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    logic [31:0] m_cmd, m_bar, m_intl;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_regbank #(
        .VENDOR_ID (P_VID), .DEVICE_ID (P_DID), .STATUS_VALUE (P_STAT),
        .CLASS_CODE (P_CLS), .REVISION_ID (P_REV), .HEADER_TYPE (P_HDR),
        .SUBSYS_VENDOR_ID (P_SVID), .SUBSYS_ID (P_SID), .INT_PIN (P_PIN),
        .MIN_GRANT (P_MGNT), .MAX_LATENCY (P_MLAT), .BAR_ADDR_LSB (12)
    ) i_pci_cfg_regbank (
        .clk (clk), .rst_n (rst_n), .frame_n_i (frame_n), .ad_i (ad),
        .cbe_n_i (cbe_n), .irdy_n_i (irdy_n), .trdy_n_i (trdy_n),
        .rd_data_o (rd_data), .cmd_o (cmd_out), .bar_o (bar_out),
        .int_line_o (intl_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] cur, input logic [31:0] nxt,
                                        input logic [3:0] ben, input logic [31:0] mask);
        logic [31:0] r;
        r = cur;
        for (int b = 0; b < 4; b++) if (ben[b] == 1'b0) r[b*8 +: 8] = nxt[b*8 +: 8];
        return r & mask;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] c, input logic [5:0] dw);
        if (c != C_RD) return 32'h0;
        case (dw)
            6'h00:   return {P_DID, P_VID};
            6'h01:   return {P_STAT, m_cmd[15:0]};
            6'h02:   return {P_CLS, P_REV};
            6'h03:   return {8'h00, P_HDR, 16'h0000};
            6'h04:   return m_bar;
            6'h0B:   return {P_SID, P_SVID};
            6'h0F:   return {P_MLAT, P_MGNT, P_PIN, m_intl[7:0]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_regs(input string tag);
        check({tag, " cmd"},  {16'h0, cmd_out}, m_cmd);
        check({tag, " bar"},  bar_out, m_bar);
        check({tag, " intl"}, {24'h0, intl_out}, m_intl);
    endtask

    task automatic txn(input string tag, input logic [3:0] c, input logic [5:0] dw,
                       input logic [23:0] upper, input logic [31:0] wdat,
                       input logic [3:0] be, input int waits);
        logic [31:0] rdat;
        @(negedge clk);
        frame_n = 1'b0; ad = {upper, dw, 2'b00}; cbe_n = c; irdy_n = 1'b1; trdy_n = 1'b1;
        @(negedge clk);
        frame_n = 1'b1; ad = wdat; cbe_n = be;
        for (int w = 0; w < waits; w++) begin
            int p;
            p = 1 + int'($urandom_range(2));
            {irdy_n, trdy_n} = p[1:0];
            @(negedge clk);
            check_regs("R7 wait");
        end
        irdy_n = 1'b0; trdy_n = 1'b0;
        #1 rdat = rd_data;
        check(tag, rdat, exp_rd(c, dw));
        @(negedge clk);
        irdy_n = 1'b1; trdy_n = 1'b1;
        if (c == C_WR) begin
            if (dw == 6'h01) m_cmd  = mrg(m_cmd,  wdat, be, 32'h0000_FFFF);
            if (dw == 6'h04) m_bar  = mrg(m_bar,  wdat, be, 32'hFFFF_F000);
            if (dw == 6'h0F) m_intl = mrg(m_intl, wdat, be, 32'h0000_00FF);
        end
        check_regs(tag);
        #1 check({tag, " idle"}, rd_data, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cmd = '0; m_bar = '0; m_intl = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        m_cmd = '0; m_bar = '0; m_intl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_regs("R1 reset");
        check("R1 idle rd", rd_data, 32'h0);

        // R2 identification
        txn("R2 id",     C_RD, 6'h00, 24'h0, 32'h0, 4'h0, 0);
        txn("R2 class",  C_RD, 6'h02, 24'h0, 32'h0, 4'h0, 0);
        txn("R2 misc",   C_RD, 6'h03, 24'h0, 32'h0, 4'h0, 0);
        txn("R2 subsys", C_RD, 6'h0B, 24'h0, 32'h0, 4'h0, 0);
        // R3 command
        txn("R3 wr",   C_WR, 6'h01, 24'h0, 32'hFFFF_FFFF, 4'h0, 0);
        txn("R3 rd",   C_RD, 6'h01, 24'h0, 32'h0, 4'h0, 0);
        // R4 BAR sizing
        txn("R4 size", C_WR, 6'h04, 24'h0, 32'hFFFF_FFFF, 4'h0, 0);
        txn("R4 rd",   C_RD, 6'h04, 24'h0, 32'h0, 4'h0, 0);
        txn("R4 base", C_WR, 6'h04, 24'h0, 32'hC012_3ABC, 4'h0, 0);
        // R5 interrupt dword
        txn("R5 wr",   C_WR, 6'h0F, 24'h0, 32'h1234_56A5, 4'h0, 0);
        txn("R5 rd",   C_RD, 6'h0F, 24'h0, 32'h0, 4'h0, 0);
        // R6 lanes
        txn("R6 lane0", C_WR, 6'h01, 24'h0, 32'h0000_1234, 4'hE, 0);
        txn("R6 lane1", C_WR, 6'h04, 24'h0, 32'h00AB_CDEF, 4'hB, 0);
        txn("R6 none",  C_WR, 6'h0F, 24'h0, 32'h0000_0077, 4'hF, 0);
        // R7 wait states
        txn("R7 wr",   C_WR, 6'h01, 24'h0, 32'h0000_0F0F, 4'h0, 4);
        // R8 other commands
        txn("R8 mwr",  C_MWR, 6'h01, 24'h0, 32'h0000_AAAA, 4'h0, 0);
        txn("R8 mwr bar", C_MWR, 6'h04, 24'h0, 32'h5555_5000, 4'h0, 1);
        txn("R8 mrd",  C_MRD, 6'h00, 24'h0, 32'h0, 4'h0, 0);
        // R9 unimplemented
        txn("R9 w34",  C_WR, 6'h0D, 24'h0, 32'hFFFF_FFFF, 4'h0, 0);
        txn("R9 r38",  C_RD, 6'h0E, 24'h0, 32'h0, 4'h0, 0);
        txn("R9 w40",  C_WR, 6'h10, 24'h0, 32'hFFFF_FFFF, 4'h0, 0);
        txn("R9 rFC",  C_RD, 6'h3F, 24'h0, 32'h0, 4'h0, 0);
        txn("R9 alias", C_WR, 6'h01, 24'h00_0100, 32'h0000_3333, 4'h0, 0);
        txn("R9 w44",  C_WR, 6'h11, 24'h0, 32'h0000_00FF, 4'h0, 0);

        // R1 mid-run reset
        do_reset();
        @(negedge clk);
        check_regs("R1 rereset");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] c;
            logic [5:0] dw;
            int sel;
            sel = int'($urandom_range(9));
            c = (sel < 4) ? C_WR : (sel < 8) ? C_RD : (sel == 8) ? C_MWR : C_MRD;
            sel = int'($urandom_range(9));
            case (sel)
                0: dw = 6'h00; 1: dw = 6'h01; 2: dw = 6'h04; 3: dw = 6'h0F;
                4: dw = 6'h02; 5: dw = 6'h03; 6: dw = 6'h0B;
                default: dw = 6'($urandom_range(63));
            endcase
            txn("R6 R8 random", c, dw, 24'($urandom), $urandom, 4'($urandom),
                int'($urandom_range(2)));
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule